// File: doc/BRIEF.md
# Banked Register File with Mode Switching

This block holds the general-purpose registers of a 32-bit processor core. Software always sees sixteen registers, numbered 0 to 15. The lower twelve are one physical set shared by every operating mode. The upper four (12 to 15) come from a separate physical group for each of the three modes: user, supervisor and interrupt. In every mode, register 14 is the link register and register 15 is the stack pointer.

The core reads two registers combinationally and writes one per clock. The current mode selects which upper group those accesses reach.

A mode-switch request names a target mode and carries a return address. On the next clock edge the block does three things at once:
- it writes the return address into the target mode's link register;
- it copies the caller's current stack pointer into the target mode's stack pointer;
- it changes the current mode to the target.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-low reset clears every physical register to zero and sets the current mode to supervisor; mode codes are user = 0, supervisor = 1, interrupt = 2, and code 3 is reserved.
- R2: Registers 0 to 11 are a single set: a value written to one of them in any mode reads back unchanged in every other mode.
- R3: Registers 12 to 15 are held separately per mode: a write to one of them changes only the copy that belongs to the mode current at that clock.
- R4: Both read ports return, combinationally and independently, the register named by their own 4-bit address, taking registers 12 to 15 from the current mode's group.
- R5: A write becomes visible on the clock edge that accepts it. A read of the same register in the same cycle returns the value it held before that write.
- R6: An accepted switch request (target code 0 to 2) takes effect on one clock edge. The current mode becomes the target. The target's register 14 receives the return address. The target's register 15 receives the value that register 15 of the mode current before the edge held.
- R7: When a switch request is accepted, a register write presented in the same cycle is dropped and changes no register.
- R8: A switch request with target code 3 is ignored: the mode and every register stay as they were, and a write in the same cycle proceeds normally.
- R9: Without an accepted switch request the mode holds its value. A switch leaves registers 12 and 13 of every group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 4 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the register named on port A |
| rd_addr_b | input | 4 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the register named on port B |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 32 | Value to write |
| sw_req | input | 1 | Mode-switch request |
| sw_mode | input | 2 | Target mode of the switch request |
| sw_ret | input | 32 | Return address saved into the target's link register |
| cur_mode | output | 2 | Mode currently in effect |

## Verification
Each kind of internal fault shows up at the ports in a different way:
- A mode register that loads the wrong value shows on `cur_mode` one clock after the faulty edge. It also makes every later read of registers 12 to 15 return another group's contents.
- A save that lands in the wrong group, or that copies the stack pointer after the edge instead of before it, stays hidden until registers 14 and 15 are read in the target mode. For that reason the stimulus reads them on the clock right after each switch.
- A write that leaks into the wrong group, or that survives a concurrent switch, only shows once the affected mode is entered again. The sequence therefore comes back to each mode and reads its upper registers again.

// File: rtl/regbank_pkg.sv
// Shared definitions for the banked register file: the operating mode
// encoding and the number of modes that own a private upper group.
package regbank_pkg;

    typedef enum logic [1:0] {
        MODE_USER  = 2'd0,
        MODE_SUPER = 2'd1,
        MODE_IRQ   = 2'd2,
        MODE_RSVD  = 2'd3
    } cpu_mode_e;

    localparam int NUM_MODES = 3;

endpackage

// File: rtl/regbank_mode.sv
// Mode tracker. Holds the current operating mode and decides whether a
// switch request is legal (target below NUM_MODES).
// Assumes: synchronous active-low reset, after which the mode is supervisor.
module regbank_mode
    import regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic [1:0] sw_mode,
    output logic [1:0] mode_o,
    output logic       accept_o
);

    logic [1:0] mode_q;

    // A request is accepted only when its target names a real mode.
    assign accept_o = sw_req && (sw_mode < 2'(NUM_MODES));
    assign mode_o   = mode_q;

    // Load the target mode on an accepted request; reset to supervisor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_SUPER;
        else if (accept_o)
            mode_q <= sw_mode;
    end

    assert_mode_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (mode_o == $past(sw_mode)));

    assert_mode_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_req |=> $stable(mode_o));

    assert_rsvd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && sw_mode == MODE_RSVD) |=> $stable(mode_o));

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != MODE_RSVD);

endmodule

// File: rtl/regbank_shared.sv
// Shared lower register set, seen identically by all modes.
// One write port, two combinational read ports. Index values at or above
// NUM_ENT read as zero and never write; the caller routes those elsewhere.
module regbank_shared #(
    parameter int DATA_W  = 32,
    parameter int NUM_ENT = 12,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);

    logic [DATA_W-1:0] regs_q [NUM_ENT];

    // Store the write data into the addressed entry; clear all on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                regs_q[i] <= wr_data;
        end
    end

    // Select the two read values by comparing against each entry.
    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (rd_idx_a == IDX_W'(i)) rd_a = regs_q[i];
            if (rd_idx_b == IDX_W'(i)) rd_b = regs_q[i];
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_hold
        assert_shared_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/regbank_bank.sv
// One mode's private upper group. The last two entries are the link
// register and stack pointer. A save loads both of them on one edge and
// takes priority over an ordinary write to this group.
module regbank_bank #(
    parameter int DATA_W  = 32,
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            save_en,
    input  logic [DATA_W-1:0]               save_lr,
    input  logic [DATA_W-1:0]               save_sp,
    output logic [NUM_ENT-1:0][DATA_W-1:0]  regs_o
);

    localparam int LR_IDX = NUM_ENT - 2;
    localparam int SP_IDX = NUM_ENT - 1;

    logic [NUM_ENT-1:0][DATA_W-1:0] regs_q;

    assign regs_o = regs_q;

    // Apply a save (link + stack) or else an ordinary write; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (save_en) begin
            regs_q[LR_IDX] <= save_lr;
            regs_q[SP_IDX] <= save_sp;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    assert_save_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> (regs_q[LR_IDX] == $past(save_lr)) && (regs_q[SP_IDX] == $past(save_sp)));

    assert_save_keeps_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> $stable(regs_q[0]) && $stable(regs_q[1]));

endmodule

// File: rtl/banked_regfile.sv
// Top of the banked register file. Routes register numbers below
// SHARED_REGS to the shared set and the rest to the current mode's private
// group. Turns an accepted switch request into a save in the target group.
// Assumes: BANKED_REGS >= 2, so the link and stack registers exist.
module banked_regfile
    import regbank_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NUM_REGS    = 16,
    parameter int BANKED_REGS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(NUM_REGS)-1:0]     rd_addr_a,
    output logic [DATA_W-1:0]               rd_data_a,
    input  logic [$clog2(NUM_REGS)-1:0]     rd_addr_b,
    output logic [DATA_W-1:0]               rd_data_b,
    input  logic                            wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]     wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            sw_req,
    input  logic [1:0]                      sw_mode,
    input  logic [DATA_W-1:0]               sw_ret,
    output logic [1:0]                      cur_mode
);

    localparam int ADDR_W      = $clog2(NUM_REGS);
    localparam int SHARED_REGS = NUM_REGS - BANKED_REGS;
    localparam int BIDX_W      = $clog2(BANKED_REGS);
    localparam int LR_IDX      = BANKED_REGS - 2;
    localparam int SP_IDX      = BANKED_REGS - 1;

    logic                                  accept;
    logic                                  wr_live;
    logic                                  wr_hi;
    logic [BIDX_W-1:0]                     wr_bidx;
    logic [DATA_W-1:0]                     sh_rd_a, sh_rd_b;
    logic [DATA_W-1:0]                     caller_sp;
    logic [BANKED_REGS-1:0][DATA_W-1:0]    bank_regs [NUM_MODES];
    logic [BANKED_REGS-1:0][DATA_W-1:0]    cur_bank;
    logic [NUM_MODES-1:0]                  bank_wr;
    logic [NUM_MODES-1:0]                  bank_save;

    regbank_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_req),
        .sw_mode  (sw_mode),
        .mode_o   (cur_mode),
        .accept_o (accept)
    );

    // A switch save wins over the ordinary write presented with it.
    assign wr_live = wr_en && !accept;
    assign wr_hi   = wr_addr >= ADDR_W'(SHARED_REGS);
    assign wr_bidx = BIDX_W'(wr_addr - ADDR_W'(SHARED_REGS));

    regbank_shared #(
        .DATA_W  (DATA_W),
        .NUM_ENT (SHARED_REGS),
        .IDX_W   (ADDR_W)
    ) u_shared (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_live && !wr_hi),
        .wr_idx   (wr_addr),
        .wr_data  (wr_data),
        .rd_idx_a (rd_addr_a),
        .rd_idx_b (rd_addr_b),
        .rd_a     (sh_rd_a),
        .rd_b     (sh_rd_b)
    );

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_bank
        assign bank_wr[m]   = wr_live && wr_hi && (cur_mode == 2'(m));
        assign bank_save[m] = accept && (sw_mode == 2'(m));

        regbank_bank #(
            .DATA_W  (DATA_W),
            .NUM_ENT (BANKED_REGS),
            .IDX_W   (BIDX_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[m]),
            .wr_idx  (wr_bidx),
            .wr_data (wr_data),
            .save_en (bank_save[m]),
            .save_lr (sw_ret),
            .save_sp (caller_sp),
            .regs_o  (bank_regs[m])
        );
    end

    // Pick the private group that belongs to the current mode.
    always_comb begin
        cur_bank = '0;
        for (int m = 0; m < NUM_MODES; m++)
            if (cur_mode == 2'(m)) cur_bank = bank_regs[m];
    end

    assign caller_sp = cur_bank[SP_IDX];

    // Route each read port to the shared set or the current group.
    always_comb begin
        rd_data_a = (rd_addr_a < ADDR_W'(SHARED_REGS)) ? sh_rd_a
                  : cur_bank[BIDX_W'(rd_addr_a - ADDR_W'(SHARED_REGS))];
        rd_data_b = (rd_addr_b < ADDR_W'(SHARED_REGS)) ? sh_rd_b
                  : cur_bank[BIDX_W'(rd_addr_b - ADDR_W'(SHARED_REGS))];
    end

    assert_switch_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cur_bank[LR_IDX] == $past(sw_ret)) && (cur_bank[SP_IDX] == $past(caller_sp)));

    assert_no_dual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_save & bank_wr) == '0);

    assert_one_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_save));

endmodule

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// read values and mode from a requirement-level model, and queues them.
// The monitor pops them and compares 1 ns before the next rising edge.
module banked_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, sw_ret = '0;
    logic        wr_en = 1'b0, sw_req = 1'b0;
    logic [1:0]  sw_mode = '0, cur_mode;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_a_q [$];
    logic [31:0] exp_b_q [$];
    logic [1:0]  exp_m_q [$];
    string       tag_q   [$];

    // Model state, written from the requirements only.
    logic [31:0] m_sh [12];
    logic [31:0] m_bk [3][4];
    logic [1:0]  m_mode;

    always #2 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sw_req(sw_req), .sw_mode(sw_mode), .sw_ret(sw_ret),
        .cur_mode(cur_mode)
    );

    function automatic logic [31:0] mread(logic [3:0] a);
        return (a < 4'd12) ? m_sh[a] : m_bk[m_mode][a - 4'd12];
    endfunction

    // Drive one cycle, queue its expected outputs, then advance the model.
    task automatic cycle(bit we, logic [3:0] wa, logic [31:0] wd,
                         bit sr, logic [1:0] sm, logic [31:0] sret,
                         logic [3:0] ra, logic [3:0] rb, string tag);
        logic [31:0] old_sp;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        sw_req = sr; sw_mode = sm; sw_ret = sret;
        rd_addr_a = ra; rd_addr_b = rb;
        exp_a_q.push_back(mread(ra));
        exp_b_q.push_back(mread(rb));
        exp_m_q.push_back(m_mode);
        tag_q.push_back(tag);
        old_sp = m_bk[m_mode][3];
        if (sr && sm != 2'd3) begin
            m_bk[sm][2] = sret;
            m_bk[sm][3] = old_sp;
            m_mode = sm;
        end else if (we) begin
            if (wa < 4'd12) m_sh[wa] = wd;
            else            m_bk[m_mode][wa - 4'd12] = wd;
        end
    endtask

    task automatic rd(logic [3:0] ra, logic [3:0] rb, string tag);
        cycle(1'b0, 4'd0, 32'd0, 1'b0, 2'd0, 32'd0, ra, rb, tag);
    endtask

    task automatic wr(logic [3:0] wa, logic [31:0] wd, string tag);
        cycle(1'b1, wa, wd, 1'b0, 2'd0, 32'd0, wa, wa, tag);
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare queued expectations just before the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (tag_q.size() != 0) begin
                string t;
                t = tag_q.pop_front();
                chk(t, "rd_data_a", rd_data_a, exp_a_q.pop_front());
                chk(t, "rd_data_b", rd_data_b, exp_b_q.pop_front());
                chk(t, "cur_mode", {30'd0, cur_mode}, {30'd0, exp_m_q.pop_front()});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) m_sh[i] = '0;
        for (int m = 0; m < 3; m++)
            for (int j = 0; j < 4; j++) m_bk[m][j] = '0;
        m_mode = 2'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers zero and supervisor mode after reset
        for (int i = 0; i < 8; i++) rd(4'(2*i), 4'(2*i+1), "R1");

        // R5: same-cycle read sees the old value, next cycle the new one
        wr(4'd3, 32'hA0A0_0003, "R5");
        rd(4'd3, 4'd0, "R5");
        // R4: two ports, independent addresses
        wr(4'd11, 32'h0000_0B0B, "R4");
        rd(4'd11, 4'd3, "R4");

        // Fill supervisor upper group
        wr(4'd12, 32'h5000_000C, "R3");
        wr(4'd13, 32'h5000_000D, "R3");
        wr(4'd14, 32'h5000_000E, "R3");
        wr(4'd15, 32'h5000_000F, "R3");
        rd(4'd12, 4'd15, "R4");

        // R6: switch to user, save return address and caller stack pointer
        cycle(1'b0, 4'd0, 32'd0, 1'b1, 2'd0, 32'h0000_1000, 4'd14, 4'd15, "R6");
        rd(4'd14, 4'd15, "R6");
        rd(4'd12, 4'd13, "R9");
        rd(4'd3, 4'd11, "R2");

        // R3: user writes stay in the user group
        wr(4'd12, 32'hCC00_0012, "R3");
        wr(4'd15, 32'hCC00_0015, "R3");
        rd(4'd12, 4'd15, "R3");

        // R7: switch to interrupt mode drops a concurrent write
        cycle(1'b1, 4'd5, 32'hDEAD_0005, 1'b1, 2'd2, 32'h0000_2000, 4'd5, 4'd15, "R7");
        rd(4'd5, 4'd14, "R7");
        rd(4'd14, 4'd15, "R6");
        rd(4'd12, 4'd13, "R9");

        // R8: reserved target is ignored, concurrent write proceeds
        cycle(1'b1, 4'd6, 32'h0000_E006, 1'b1, 2'd3, 32'h0000_3000, 4'd14, 4'd6, "R8");
        rd(4'd6, 4'd14, "R8");
        rd(4'd15, 4'd12, "R8");

        // R7: concurrent write to the stack pointer is dropped on a switch
        cycle(1'b1, 4'd15, 32'hBAD0_BAD0, 1'b1, 2'd1, 32'h0000_4000, 4'd15, 4'd14, "R7");
        // R3: supervisor group kept its own values
        rd(4'd12, 4'd13, "R3");
        rd(4'd14, 4'd15, "R6");

        // R2: shared value written in supervisor seen from user
        wr(4'd7, 32'h7777_0007, "R2");
        cycle(1'b0, 4'd0, 32'd0, 1'b1, 2'd0, 32'h0000_5000, 4'd7, 4'd12, "R2");
        rd(4'd7, 4'd12, "R2");
        rd(4'd14, 4'd15, "R6");

        // R6: switch to the mode already current
        cycle(1'b0, 4'd0, 32'd0, 1'b1, 2'd0, 32'h0000_6000, 4'd14, 4'd15, "R6");
        rd(4'd14, 4'd15, "R6");

        // R9: mode holds across idle cycles
        for (int i = 0; i < 4; i++) rd(4'd13, 4'd0, "R9");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule